// File: doc/BRIEF.md
# Pixel Format Packer

The packer sits between a compositor and a memory writer. It accepts one 32-bit pixel per cycle over a valid/ready stream, with alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. It converts each pixel to one of twelve output formats chosen by a 4-bit code. It then packs the resulting bytes into 32-bit words, each with a per-byte write strobe.

Sixteen-bit formats place two pixels in each word. The 24-bit formats run their bytes across word boundaries. The 32-bit formats fill one word per pixel. Alpha can be stored, stored inverted, or replaced by a constant. A 4-bit lane mask gates the strobe of each byte lane.

An input marker flags the last pixel of a frame. The packer then closes the frame, pushing out any partly filled word with strobes on its valid bytes only.

Top module: `pixel_packer`

## Requirements
- R1: After reset, out_valid and fmt_err are 0 and in_ready is 1.
- R2: Codes 12 to 15 emit one word per pixel, listed from byte 3 down to byte 0: 12 = A,B,G,R; 13 = A,R,G,B; 14 = B,G,R,A; 15 = R,G,B,A. The strobe is all four lanes.
- R3: Codes 0 to 3 keep bits 7:4 of each channel, listed from bits 15:12 down to 3:0: 0 = A,B,G,R; 1 = A,R,G,B; 2 = B,G,R,A; 3 = R,G,B,A. Each pixel takes two bytes. The first pixel of a word lands in bits 15:0.
- R4: Code 6 packs {B[7:3],G[7:2],R[7:3]} and code 7 packs {R[7:3],G[7:2],B[7:3]}, most significant field first. Each pixel is two bytes, packed two per word as in R3.
- R5: Code 8 yields bytes {B,G,R} and code 9 yields {R,G,B}, most significant first. The three bytes of a pixel enter the output stream lowest byte first. Stream byte k goes to lane k mod 4 of word k div 4.
- R6: With alpha_keep set, the alpha field of codes 0 to 3 and 12 to 15 carries the input alpha. It is inverted when alpha_flip is set.
- R7: With alpha_keep clear, the alpha field holds all ones when alpha_flip is set and all zeros when it is clear.
- R8: Strobe bit k of every output word is ANDed with lane_en[k].
- R9: Codes 4, 5, 10 and 11 consume pixels without producing output words. Accepting such a pixel sets fmt_err, and fmt_err stays set until reset.
- R10: A pixel accepted with in_last set closes the frame. The final word of the frame carries out_last. When that word holds n < 4 stream bytes, only strobe bits 0 to n-1 may be set. When the last pixel overflows one word, the packer issues a second word and holds in_ready low until that word is loaded.
- R11: While out_valid is high and out_ready is low, out_data, out_strb and out_last hold their values and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 4 | Output format code |
| alpha_keep | input | 1 | Store alpha instead of a constant fill |
| alpha_flip | input | 1 | Invert stored alpha, or pick all-ones fill |
| lane_en | input | 4 | Per-lane strobe enable |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer accepts a pixel this cycle |
| in_pixel | input | 32 | Pixel, alpha/red/green/blue from the top byte down |
| in_last | input | 1 | Last pixel of the frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed word |
| out_strb | output | 4 | Byte write strobes |
| out_last | output | 1 | Final word of the frame |
| fmt_err | output | 1 | Sticky flag for an undefined format code |

## Verification
The block has no parameters, so the bench builds it exactly as it is used. Because of that, the bench spends its effort on the configuration inputs. Each frame draws a random format code, alpha mode and frame length, and some frames also draw a random lane mask. Frame lengths from one to twelve pixels reach every leftover count of the 16-bit and 24-bit packing, including the case where the last pixel spills into a second word. Downstream readiness is randomised in some frames to exercise holding under stall. Directed frames cover the alpha fills, the undefined codes and a reset clearing the sticky flag.

// File: rtl/pixel_packer.sv
module pixel_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fmt_sel,
  input  logic        alpha_keep,
  input  logic        alpha_flip,
  input  logic [3:0]  lane_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_pixel,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_strb,
  output logic        out_last,
  output logic        fmt_err
);

  logic [7:0]  ch_a, ch_r, ch_g, ch_b, a_val;
  logic [31:0] pix_word;
  logic [2:0]  pix_n;
  logic        fmt_bad;

  logic [23:0] pend;
  logic [1:0]  pend_n;
  logic        flush_pend;

  logic [55:0] comb;
  logic [2:0]  total;
  logic        out_free, take;

  assign ch_a = in_pixel[31:24];
  assign ch_r = in_pixel[23:16];
  assign ch_g = in_pixel[15:8];
  assign ch_b = in_pixel[7:0];

  assign a_val = alpha_keep ? (alpha_flip ? ~ch_a : ch_a) : {8{alpha_flip}};

  always_comb begin
    pix_word = '0;
    pix_n    = 3'd0;
    fmt_bad  = 1'b0;
    case (fmt_sel)
      4'd0:  begin pix_word = {16'b0, a_val[7:4], ch_b[7:4], ch_g[7:4], ch_r[7:4]}; pix_n = 3'd2; end
      4'd1:  begin pix_word = {16'b0, a_val[7:4], ch_r[7:4], ch_g[7:4], ch_b[7:4]}; pix_n = 3'd2; end
      4'd2:  begin pix_word = {16'b0, ch_b[7:4], ch_g[7:4], ch_r[7:4], a_val[7:4]}; pix_n = 3'd2; end
      4'd3:  begin pix_word = {16'b0, ch_r[7:4], ch_g[7:4], ch_b[7:4], a_val[7:4]}; pix_n = 3'd2; end
      4'd6:  begin pix_word = {16'b0, ch_b[7:3], ch_g[7:2], ch_r[7:3]}; pix_n = 3'd2; end
      4'd7:  begin pix_word = {16'b0, ch_r[7:3], ch_g[7:2], ch_b[7:3]}; pix_n = 3'd2; end
      4'd8:  begin pix_word = {8'b0, ch_b, ch_g, ch_r}; pix_n = 3'd3; end
      4'd9:  begin pix_word = {8'b0, ch_r, ch_g, ch_b}; pix_n = 3'd3; end
      4'd12: begin pix_word = {a_val, ch_b, ch_g, ch_r}; pix_n = 3'd4; end
      4'd13: begin pix_word = {a_val, ch_r, ch_g, ch_b}; pix_n = 3'd4; end
      4'd14: begin pix_word = {ch_b, ch_g, ch_r, a_val}; pix_n = 3'd4; end
      4'd15: begin pix_word = {ch_r, ch_g, ch_b, a_val}; pix_n = 3'd4; end
      default: fmt_bad = 1'b1;
    endcase
  end

  function automatic logic [3:0] lanes_of(input logic [2:0] n);
    case (n)
      3'd0:    lanes_of = 4'b0000;
      3'd1:    lanes_of = 4'b0001;
      3'd2:    lanes_of = 4'b0011;
      3'd3:    lanes_of = 4'b0111;
      default: lanes_of = 4'b1111;
    endcase
  endfunction

  assign comb     = {32'b0, pend} | ({24'b0, pix_word} << {pend_n, 3'b000});
  assign total    = {1'b0, pend_n} + pix_n;
  assign out_free = !out_valid || out_ready;
  assign in_ready = out_free && !flush_pend;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_strb   <= '0;
      out_last   <= 1'b0;
      pend       <= '0;
      pend_n     <= '0;
      flush_pend <= 1'b0;
      fmt_err    <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush_pend && out_free) begin
        out_valid  <= 1'b1;
        out_data   <= {8'b0, pend};
        out_strb   <= lanes_of({1'b0, pend_n}) & lane_en;
        out_last   <= 1'b1;
        pend       <= '0;
        pend_n     <= '0;
        flush_pend <= 1'b0;
      end else if (take) begin
        if (fmt_bad) fmt_err <= 1'b1;
        if (total >= 3'd4) begin
          out_valid  <= 1'b1;
          out_data   <= comb[31:0];
          out_strb   <= lane_en;
          out_last   <= in_last && (total == 3'd4);
          pend       <= comb[55:32];
          pend_n     <= 2'(total - 3'd4);
          flush_pend <= in_last && (total > 3'd4);
        end else if (in_last && total != 3'd0) begin
          out_valid  <= 1'b1;
          out_data   <= {8'b0, comb[23:0]};
          out_strb   <= lanes_of(total) & lane_en;
          out_last   <= 1'b1;
          pend       <= '0;
          pend_n     <= '0;
        end else begin
          pend   <= comb[23:0];
          pend_n <= total[1:0];
        end
      end
    end
  end

endmodule

module pixel_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  fmt_sel,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [3:0]  out_strb,
  input logic        out_last,
  input logic        fmt_err
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_strb) && $stable(out_last));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (fmt_sel == 4'd4 || fmt_sel == 4'd5 || fmt_sel == 4'd10 || fmt_sel == 4'd11)
    |=> fmt_err);

endmodule

bind pixel_packer pixel_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb),
  .out_last(out_last), .fmt_err(fmt_err)
);

// File: tb/test_pixel_packer.sv
module test_pixel_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  fmt_sel = 4'd13;
  logic        alpha_keep = 1'b1, alpha_flip = 1'b0;
  logic [3:0]  lane_en = 4'hF;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_pixel = '0;
  logic        in_ready, out_valid, out_last, fmt_err;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_strb;

  always #5 clk = ~clk;

  pixel_packer i_pixel_packer (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_data [0:4095];
  logic [3:0]  e_strb [0:4095];
  logic        e_last [0:4095];
  string       e_req  [0:4095];
  int wr = 0, rd = 0;
  bit stall_mode = 0;
  bit hold_pend = 0;
  logic [31:0] hd; logic [3:0] hs; logic hl;
  logic [31:0] px [0:15];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [34:0] conv(input logic [31:0] p, input logic [3:0] f,
                                       input bit aen, input bit ainv);
    logic [7:0] a, r, g, b;
    a = aen ? (ainv ? ~p[31:24] : p[31:24]) : (ainv ? 8'hFF : 8'h00);
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    case (f)
      4'd0:  return {3'd2, 16'b0, a[7:4], b[7:4], g[7:4], r[7:4]};
      4'd1:  return {3'd2, 16'b0, a[7:4], r[7:4], g[7:4], b[7:4]};
      4'd2:  return {3'd2, 16'b0, b[7:4], g[7:4], r[7:4], a[7:4]};
      4'd3:  return {3'd2, 16'b0, r[7:4], g[7:4], b[7:4], a[7:4]};
      4'd6:  return {3'd2, 16'b0, b[7:3], g[7:2], r[7:3]};
      4'd7:  return {3'd2, 16'b0, r[7:3], g[7:2], b[7:3]};
      4'd8:  return {3'd3, 8'b0, b, g, r};
      4'd9:  return {3'd3, 8'b0, r, g, b};
      4'd12: return {3'd4, a, b, g, r};
      4'd13: return {3'd4, a, r, g, b};
      4'd14: return {3'd4, b, g, r, a};
      4'd15: return {3'd4, r, g, b, a};
      default: return 35'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    out_ready = stall_mode ? ($urandom % 4 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) hold_pend = 0;
    else begin
      if (hold_pend) begin
        chk(out_valid && out_data == hd && out_strb == hs && out_last == hl, "R11",
            "word changed under stall", {out_valid, out_last, out_strb, out_data},
            {1'b1, hl, hs, hd});
        hold_pend = 0;
      end
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R11", "in_ready during stall", 64'(in_ready), 64'd0);
        hold_pend = 1; hd = out_data; hs = out_strb; hl = out_last;
      end
      if (out_valid && out_ready) begin
        if (rd >= wr) chk(0, "R9", "unexpected output word", 64'(out_data), 64'd0);
        else begin
          chk(out_strb == e_strb[rd] && out_last == e_last[rd] &&
              (out_data & mask_of(e_strb[rd])) == (e_data[rd] & mask_of(e_strb[rd])),
              e_req[rd], "output word",
              {out_last, out_strb, out_data & mask_of(out_strb)},
              {e_last[rd], e_strb[rd], e_data[rd] & mask_of(e_strb[rd])});
          rd++;
        end
      end
    end
  end

  task automatic send(input logic [31:0] p, input bit l);
    in_valid = 1'b1; in_pixel = p; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((rd != wr || out_valid) && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_frame(input logic [3:0] f, input bit aen, input bit ainv,
                           input logic [3:0] le, input int len, input bit st, input string tag);
    logic [7:0] fb [0:63];
    int nb = 0;
    logic [34:0] cv;
    stall_mode = st;
    fmt_sel = f; alpha_keep = aen; alpha_flip = ainv; lane_en = le;
    for (int i = 0; i < len; i++) begin
      cv = conv(px[i], f, aen, ainv);
      for (int k = 0; k < int'(cv[34:32]); k++) begin fb[nb] = cv[8*k +: 8]; nb++; end
    end
    for (int w = 0; w < nb; w += 4) begin
      int cnt = (nb - w >= 4) ? 4 : nb - w;
      logic [31:0] d = '0;
      for (int k = 0; k < cnt; k++) d[8*k +: 8] = fb[w + k];
      e_data[wr] = d;
      e_strb[wr] = 4'((1 << cnt) - 1) & le;
      e_last[wr] = (w + 4 >= nb);
      e_req[wr]  = (cnt < 4) ? "R10" : tag;
      wr++;
    end
    for (int i = 0; i < len; i++) send(px[i], i == len - 1);
    drain();
  endtask

  task automatic final_report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 64'(rd), 64'(wr));
    final_report();
  end

  initial begin
    logic [3:0] codes [0:11] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && fmt_err == 0, "R1", "reset state",
        {in_ready, out_valid, fmt_err}, 3'b100);

    px[0] = 32'h11223344;
    run_frame(4'd13, 1, 0, 4'hF, 1, 0, "R2");
    px[0] = 32'hAA112233; px[1] = 32'h80F00F55;
    run_frame(4'd15, 1, 1, 4'hF, 2, 0, "R6");
    run_frame(4'd1, 1, 1, 4'hF, 2, 0, "R6");
    run_frame(4'd0, 0, 1, 4'hF, 2, 0, "R7");
    run_frame(4'd14, 0, 0, 4'hF, 2, 0, "R7");
    run_frame(4'd7, 1, 0, 4'hF, 2, 0, "R4");
    run_frame(4'd3, 1, 0, 4'hF, 2, 0, "R3");
    for (int i = 0; i < 16; i++) px[i] = $urandom;
    run_frame(4'd8, 1, 0, 4'hF, 4, 0, "R5");
    run_frame(4'd9, 1, 0, 4'hF, 5, 1, "R5");
    run_frame(4'd6, 1, 0, 4'hF, 3, 0, "R4");
    run_frame(4'd12, 1, 0, 4'h5, 3, 1, "R8");

    for (int n = 0; n < 70; n++) begin
      logic [3:0] f = codes[$urandom % 12];
      logic [3:0] le = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      string tag = (le != 4'hF) ? "R8" : (f >= 12) ? "R2" : (f <= 3) ? "R3" : (f <= 7) ? "R4" : "R5";
      for (int i = 0; i < 16; i++) px[i] = $urandom;
      run_frame(f, 1'($urandom), 1'($urandom), le, 1 + $urandom % 12, 1'($urandom), tag);
    end

    run_frame(4'd10, 1, 0, 4'hF, 3, 0, "R9");
    chk(fmt_err == 1 && rd == wr, "R9", "undefined code flags error, no words", {fmt_err, 32'(wr - rd)}, {1'b1, 32'd0});
    run_frame(4'd13, 1, 0, 4'hF, 2, 0, "R2");
    chk(fmt_err == 1, "R9", "error flag stays set", 64'(fmt_err), 64'd1);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && fmt_err == 0, "R1", "state after second reset",
        {in_ready, out_valid, fmt_err}, 3'b100);
    final_report();
  end
endmodule